// File: doc/BRIEF.md
# Instruction Length and Operand Address Generator

This block sits at the front of an instruction pipeline. It receives up to three halfwords of an instruction, the address the instruction was fetched from, and the size of the storage operand the instruction works on. From the two leading op-code bits it finds the format class and the instruction length. It extracts the register fields and reads base and index values through three read-select ports of a 16-entry general register file. It then forms one or two 24-bit effective storage addresses.

Each address is the sum of a base value, an optional index value and a 12-bit displacement, taken modulo 2^24. Every address is checked against the operand's natural alignment and against the installed storage size, which is a parameter. The results are registered and appear together one cycle after the request. Any misalignment wins over an out-of-range condition.

Top module: `insn_addr_gen`

## Requirements
- R1: The format is taken from in_hw0[15:14]: 00 gives format 0 with length 1, 01 gives format 1 with length 2, 10 gives format 2 with length 2, and 11 gives format 3 with length 3. Length is counted in halfwords and is placed on out_len.
- R2: In format 1, out_ea1 is the sum of the low 24 bits of the register chosen by in_hw0[3:0] (the index), the low 24 bits of the register chosen by in_hw1[15:12] (the base), and the displacement in_hw1[11:0]. Register bits 31:24 have no effect.
- R3: In format 2, out_ea1 is base plus displacement taken from in_hw1, and the index register has no effect.
- R4: In format 3, out_ea1 comes from in_hw1 and out_ea2 comes from in_hw2, each formed as base plus displacement. out_ea2_vld is 1 only in format 3.
- R5: Address sums wrap modulo 2^24, so a carry out of bit 23 is discarded.
- R6: Format 0 produces no storage address. out_ea1_vld and out_ea2_vld are 0, both addresses read 0, and only R8 can raise an exception.
- R7: in_opsize encodes the operand size as 0=1, 1=2, 2=4 and 3=8 bytes. A valid address whose low log2(size) bits are not all zero sets out_spec_exc.
- R8: An odd in_iaddr sets out_spec_exc in every format.
- R9: out_addr_exc is set when any valid address plus the operand size exceeds STORE_BYTES, meaning some byte of the operand lies beyond the installed storage. An operand that ends exactly at the limit is legal.
- R10: When out_spec_exc is 1, out_addr_exc is 0.
- R11: All results update on the clock edge that samples in_valid=1, so they are visible one cycle later with out_valid=1. With in_valid=0, out_valid drops to 0 and the other outputs hold their values.
- R12: After reset, every output is 0.
- R13: out_r1 carries in_hw0[7:4] and out_r2 carries in_hw0[3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| in_hw0 | input | 16 | First halfword (op code and register fields) |
| in_hw1 | input | 16 | Second halfword |
| in_hw2 | input | 16 | Third halfword |
| in_iaddr | input | 24 | Address of the instruction |
| in_opsize | input | 2 | Operand size code |
| rf_sel_x | output | 4 | Register file read select for the index |
| rf_sel_b1 | output | 4 | Register file read select for the first base |
| rf_sel_b2 | output | 4 | Register file read select for the second base |
| rf_val_x | input | 32 | Index register value, same cycle |
| rf_val_b1 | input | 32 | First base register value, same cycle |
| rf_val_b2 | input | 32 | Second base register value, same cycle |
| out_valid | output | 1 | Results below are new this cycle |
| out_fmt | output | 2 | Format class |
| out_len | output | 2 | Length in halfwords |
| out_r1 | output | 4 | First register field |
| out_r2 | output | 4 | Second register or index field |
| out_ea1 | output | 24 | First effective address |
| out_ea1_vld | output | 1 | First address is meaningful |
| out_ea2 | output | 24 | Second effective address |
| out_ea2_vld | output | 1 | Second address is meaningful |
| out_spec_exc | output | 1 | Specification exception |
| out_addr_exc | output | 1 | Addressing exception |

## Verification
Every result is due exactly one cycle after the request. The register file reads are combinational and land in the same cycle as the request, and the output register is the only stage. The bench drives each request just after a falling edge. On the next falling edge it compares all outputs with a model state that it advanced at the rising edge between the two. The comparison runs on every cycle, idle cycles included, so the hold behaviour and the one-cycle out_valid pulse are checked along with the values.

// File: rtl/ilag_pkg.sv
package ilag_pkg;

   typedef enum logic [1:0] {
      FMT_RR = 2'b00,
      FMT_RX = 2'b01,
      FMT_RS = 2'b10,
      FMT_SS = 2'b11
   } ifmt_e;

   // halfword count for each format class
   function automatic logic [1:0] fmt_len(input ifmt_e f);
      case (f)
         FMT_RR:  fmt_len = 2'd1;
         FMT_SS:  fmt_len = 2'd3;
         default: fmt_len = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/ilag_decode.sv
module ilag_decode #(
   parameter int HW_W   = 16,
   parameter int SEL_W  = 4,
   parameter int DISP_W = 12
) (
   input  logic [HW_W-1:0]   hw0,
   input  logic [HW_W-1:0]   hw1,
   input  logic [HW_W-1:0]   hw2,
   output ilag_pkg::ifmt_e   fmt,
   output logic [1:0]        len_hw,
   output logic [SEL_W-1:0]  r1,
   output logic [SEL_W-1:0]  r2,
   output logic [SEL_W-1:0]  xsel,
   output logic [SEL_W-1:0]  bsel0,
   output logic [SEL_W-1:0]  bsel1,
   output logic [DISP_W-1:0] disp0,
   output logic [DISP_W-1:0] disp1,
   output logic              use_idx,
   output logic [1:0]        op_en
);
   import ilag_pkg::*;

   if (SEL_W + DISP_W != HW_W) begin : g_bad_split
      $error("ilag_decode: base and displacement must fill one halfword");
   end
   if (2 * SEL_W + 2 > HW_W) begin : g_bad_regs
      $error("ilag_decode: register fields do not fit beside the op code");
   end

   always_comb begin
      fmt     = ifmt_e'(hw0[HW_W-1 -: 2]);
      len_hw  = fmt_len(fmt);
      r1      = hw0[2*SEL_W-1:SEL_W];
      r2      = hw0[SEL_W-1:0];
      xsel    = hw0[SEL_W-1:0];
      bsel0   = hw1[HW_W-1 -: SEL_W];
      disp0   = hw1[DISP_W-1:0];
      bsel1   = hw2[HW_W-1 -: SEL_W];
      disp1   = hw2[DISP_W-1:0];
      use_idx = (fmt == FMT_RX);
      op_en   = {fmt == FMT_SS, fmt != FMT_RR};
   end

endmodule

// File: rtl/ilag_agen.sv
module ilag_agen #(
   parameter int REG_W  = 32,
   parameter int ADDR_W = 24,
   parameter int DISP_W = 12
) (
   input  logic [REG_W-1:0]  base_val,
   input  logic [REG_W-1:0]  idx_val,
   input  logic              use_idx,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] ea
);
   if (ADDR_W > REG_W) begin : g_bad_addr
      $error("ilag_agen: address wider than register");
   end
   if (DISP_W > ADDR_W) begin : g_bad_disp
      $error("ilag_agen: displacement wider than address");
   end

   logic [ADDR_W-1:0] idx_term;
   logic [ADDR_W-1:0] disp_term;

   always_comb begin
      idx_term  = use_idx ? idx_val[ADDR_W-1:0] : '0;
      disp_term = ADDR_W'(disp);
      // carry out of the top bit is dropped: modulo 2**ADDR_W
      ea        = base_val[ADDR_W-1:0] + idx_term + disp_term;
   end

endmodule

// File: rtl/ilag_check.sv
module ilag_check #(
   parameter int          ADDR_W      = 24,
   parameter int unsigned STORE_BYTES = 32'd1048576
) (
   input  logic [ADDR_W-1:0] ea,
   input  logic [1:0]        size_code,
   output logic              misal,
   output logic              beyond
);
   localparam logic [ADDR_W:0] CAP      = (ADDR_W+1)'(STORE_BYTES);
   localparam bit              CAP_FULL = (64'(STORE_BYTES) >= (64'd1 << ADDR_W));

   if (64'(STORE_BYTES) > (64'd1 << ADDR_W)) begin : g_bad_cap
      $error("ilag_check: storage size exceeds address space");
   end
   if (ADDR_W < 3) begin : g_bad_w
      $error("ilag_check: address too narrow for doubleword alignment");
   end

   logic [2:0] low_mask;

   always_comb begin
      case (size_code)
         2'd0:    low_mask = 3'b000;
         2'd1:    low_mask = 3'b001;
         2'd2:    low_mask = 3'b011;
         default: low_mask = 3'b111;
      endcase
      misal = |(ea[2:0] & low_mask);
   end

   if (CAP_FULL) begin : g_cap_full
      // all addresses installed; an aligned operand never crosses the top
      assign beyond = 1'b0;
   end else begin : g_cap_part
      logic [ADDR_W:0] end_excl;
      always_comb begin
         end_excl = {1'b0, ea} + ((ADDR_W+1)'(1) << size_code);
         beyond   = (end_excl > CAP);
      end
   end

endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen #(
   parameter int          HW_W        = 16,
   parameter int          REG_W       = 32,
   parameter int          ADDR_W      = 24,
   parameter int          SEL_W       = 4,
   parameter int          DISP_W      = 12,
   parameter int unsigned STORE_BYTES = 32'd1048576
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [HW_W-1:0]   in_hw0,
   input  logic [HW_W-1:0]   in_hw1,
   input  logic [HW_W-1:0]   in_hw2,
   input  logic [ADDR_W-1:0] in_iaddr,
   input  logic [1:0]        in_opsize,
   output logic [SEL_W-1:0]  rf_sel_x,
   output logic [SEL_W-1:0]  rf_sel_b1,
   output logic [SEL_W-1:0]  rf_sel_b2,
   input  logic [REG_W-1:0]  rf_val_x,
   input  logic [REG_W-1:0]  rf_val_b1,
   input  logic [REG_W-1:0]  rf_val_b2,
   output logic              out_valid,
   output logic [1:0]        out_fmt,
   output logic [1:0]        out_len,
   output logic [SEL_W-1:0]  out_r1,
   output logic [SEL_W-1:0]  out_r2,
   output logic [ADDR_W-1:0] out_ea1,
   output logic              out_ea1_vld,
   output logic [ADDR_W-1:0] out_ea2,
   output logic              out_ea2_vld,
   output logic              out_spec_exc,
   output logic              out_addr_exc
);
   import ilag_pkg::*;

   localparam int N_OPS = 2;

   ifmt_e             fmt_d;
   logic [1:0]        len_d;
   logic [SEL_W-1:0]  r1_d, r2_d, xsel_d;
   logic [SEL_W-1:0]  bsel   [N_OPS];
   logic [DISP_W-1:0] disp   [N_OPS];
   logic [REG_W-1:0]  bval   [N_OPS];
   logic [ADDR_W-1:0] ea_d   [N_OPS];
   logic [N_OPS-1:0]  misal_d, beyond_d, op_en;
   logic              use_idx;
   logic              spec_d, addr_d;

   ilag_decode #(.HW_W(HW_W), .SEL_W(SEL_W), .DISP_W(DISP_W)) u_dec (
      .hw0(in_hw0), .hw1(in_hw1), .hw2(in_hw2),
      .fmt(fmt_d), .len_hw(len_d), .r1(r1_d), .r2(r2_d), .xsel(xsel_d),
      .bsel0(bsel[0]), .bsel1(bsel[1]), .disp0(disp[0]), .disp1(disp[1]),
      .use_idx(use_idx), .op_en(op_en)
   );

   assign rf_sel_x  = xsel_d;
   assign rf_sel_b1 = bsel[0];
   assign rf_sel_b2 = bsel[1];
   assign bval[0]   = rf_val_b1;
   assign bval[1]   = rf_val_b2;

   for (genvar g = 0; g < N_OPS; g++) begin : g_op
      // only the first operand may carry an index
      ilag_agen #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
         .base_val(bval[g]),
         .idx_val (rf_val_x),
         .use_idx (use_idx && (g == 0)),
         .disp    (disp[g]),
         .ea      (ea_d[g])
      );
      ilag_check #(.ADDR_W(ADDR_W), .STORE_BYTES(STORE_BYTES)) u_chk (
         .ea       (ea_d[g]),
         .size_code(in_opsize),
         .misal    (misal_d[g]),
         .beyond   (beyond_d[g])
      );
   end

   always_comb begin
      spec_d = in_iaddr[0] | (|(op_en & misal_d));
      addr_d = ~spec_d & (|(op_en & beyond_d));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_fmt      <= '0;
         out_len      <= '0;
         out_r1       <= '0;
         out_r2       <= '0;
         out_ea1      <= '0;
         out_ea1_vld  <= 1'b0;
         out_ea2      <= '0;
         out_ea2_vld  <= 1'b0;
         out_spec_exc <= 1'b0;
         out_addr_exc <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_fmt      <= fmt_d;
            out_len      <= len_d;
            out_r1       <= r1_d;
            out_r2       <= r2_d;
            out_ea1      <= op_en[0] ? ea_d[0] : '0;
            out_ea1_vld  <= op_en[0];
            out_ea2      <= op_en[1] ? ea_d[1] : '0;
            out_ea2_vld  <= op_en[1];
            out_spec_exc <= spec_d;
            out_addr_exc <= addr_d;
         end
      end
   end

endmodule

// File: rtl/insn_addr_gen_chk.sv
module insn_addr_gen_chk #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [ADDR_W-1:0] in_iaddr,
   input logic [1:0]        in_opsize,
   input logic              out_valid,
   input logic [1:0]        out_fmt,
   input logic [1:0]        out_len,
   input logic [ADDR_W-1:0] out_ea1,
   input logic              out_ea1_vld,
   input logic              out_ea2_vld,
   input logic              out_spec_exc,
   input logic              out_addr_exc
);
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R11
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R11
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_ea1) && $stable(out_fmt)); // R11
   AST_LEN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_fmt == 2'b00) == (out_len == 2'd1))
                 && ((out_fmt == 2'b11) == (out_len == 2'd3))); // R1
   AST_SECOND_SS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      out_ea2_vld |-> out_fmt == 2'b11); // R4
   AST_RR_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fmt == 2'b00) |-> !out_ea1_vld && !out_addr_exc); // R6
   AST_ODD_IADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_iaddr[0]) |=> out_spec_exc); // R8
   AST_HALF_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opsize != 2'd0) |=>
         ((out_ea1_vld && out_ea1[0]) -> out_spec_exc)); // R7
   AST_SPEC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      out_spec_exc |-> !out_addr_exc); // R10
endmodule

bind insn_addr_gen insn_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk_bind (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_iaddr(in_iaddr),
   .in_opsize(in_opsize), .out_valid(out_valid), .out_fmt(out_fmt),
   .out_len(out_len), .out_ea1(out_ea1), .out_ea1_vld(out_ea1_vld),
   .out_ea2_vld(out_ea2_vld), .out_spec_exc(out_spec_exc),
   .out_addr_exc(out_addr_exc)
);

// File: tb/insn_addr_gen_tb_top.sv
module insn_addr_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam longint CAP    = 1048576;
   localparam longint AMASK  = 64'hFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_hw0 = '0, in_hw1 = '0, in_hw2 = '0;
   logic [23:0] in_iaddr = '0;
   logic [1:0]  in_opsize = '0;
   logic [3:0]  rf_sel_x, rf_sel_b1, rf_sel_b2;
   logic [31:0] rf_val_x, rf_val_b1, rf_val_b2;
   logic        out_valid, out_ea1_vld, out_ea2_vld, out_spec_exc, out_addr_exc;
   logic [1:0]  out_fmt, out_len;
   logic [3:0]  out_r1, out_r2;
   logic [23:0] out_ea1, out_ea2;

   logic [31:0] regs [16];

   assign rf_val_x  = regs[rf_sel_x];
   assign rf_val_b1 = regs[rf_sel_b1];
   assign rf_val_b2 = regs[rf_sel_b2];

   always #(CLK_PERIOD/2) clk = ~clk;

   insn_addr_gen #(.STORE_BYTES(32'(CAP))) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_hw0(in_hw0), .in_hw1(in_hw1), .in_hw2(in_hw2),
      .in_iaddr(in_iaddr), .in_opsize(in_opsize),
      .rf_sel_x(rf_sel_x), .rf_sel_b1(rf_sel_b1), .rf_sel_b2(rf_sel_b2),
      .rf_val_x(rf_val_x), .rf_val_b1(rf_val_b1), .rf_val_b2(rf_val_b2),
      .out_valid(out_valid), .out_fmt(out_fmt), .out_len(out_len),
      .out_r1(out_r1), .out_r2(out_r2), .out_ea1(out_ea1),
      .out_ea1_vld(out_ea1_vld), .out_ea2(out_ea2), .out_ea2_vld(out_ea2_vld),
      .out_spec_exc(out_spec_exc), .out_addr_exc(out_addr_exc)
   );

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 0;

   // model state: what the outputs must show now
   longint m_valid = 0, m_fmt = 0, m_len = 0, m_r1 = 0, m_r2 = 0;
   longint m_ea1 = 0, m_v1 = 0, m_ea2 = 0, m_v2 = 0, m_spec = 0, m_addr = 0;

   task automatic chk(string req, string what, longint act, longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R11", "out_valid", out_valid, m_valid);
      chk("R1",  "out_fmt",   out_fmt,   m_fmt);
      chk("R1",  "out_len",   out_len,   m_len);
      chk("R13", "out_r1",    out_r1,    m_r1);
      chk("R13", "out_r2",    out_r2,    m_r2);
      chk("R2",  "out_ea1",   out_ea1,   m_ea1);
      chk("R6",  "out_ea1_vld", out_ea1_vld, m_v1);
      chk("R4",  "out_ea2",   out_ea2,   m_ea2);
      chk("R4",  "out_ea2_vld", out_ea2_vld, m_v2);
      chk("R7",  "out_spec_exc", out_spec_exc, m_spec);
      chk("R9",  "out_addr_exc", out_addr_exc, m_addr);
   endtask

   // one cycle: check the present state, present a request, advance the model
   task automatic cyc(bit v, logic [15:0] h0, logic [15:0] h1, logic [15:0] h2,
                      logic [23:0] ia, logic [1:0] sz);
      longint f, bytes, a1, a2, e1, e2, s, ad;
      @(negedge clk);
      compare_all();
      in_valid = v; in_hw0 = h0; in_hw1 = h1; in_hw2 = h2;
      in_iaddr = ia; in_opsize = sz;
      f     = h0 >> 14;
      bytes = 1 << sz;
      a1 = (longint'(regs[h1 >> 12]) & AMASK) + (h1 & 16'h0FFF);
      if (f == 1) a1 = a1 + (longint'(regs[h0 & 4'hF]) & AMASK);
      a1 = a1 % (AMASK + 1);
      a2 = ((longint'(regs[h2 >> 12]) & AMASK) + (h2 & 16'h0FFF)) % (AMASK + 1);
      e1 = (f != 0);
      e2 = (f == 3);
      s  = ia % 2;
      if (e1 && (a1 % bytes != 0)) s = 1;
      if (e2 && (a2 % bytes != 0)) s = 1;
      ad = 0;
      if (e1 && a1 + bytes > CAP) ad = 1;
      if (e2 && a2 + bytes > CAP) ad = 1;
      if (s != 0) ad = 0;
      @(posedge clk);
      m_valid = v;
      if (v) begin
         m_fmt = f;
         m_len = (f == 0) ? 1 : (f == 3) ? 3 : 2;
         m_r1 = (h0 >> 4) & 4'hF; m_r2 = h0 & 4'hF;
         m_ea1 = e1 ? a1 : 0; m_v1 = e1;
         m_ea2 = e2 ? a2 : 0; m_v2 = e2;
         m_spec = s; m_addr = ad;
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) regs[i] = 32'h0;
      regs[2] = 32'hFF00_2000;  // top byte must be ignored
      regs[3] = 32'h0000_4000;
      regs[4] = 32'h0001_0000;
      regs[5] = 32'h00FF_FFF0;
      regs[6] = 32'h000F_FFFC;
      regs[7] = 32'hAB00_1000;
      regs[8] = 32'h000F_FFF8;
      // R12: outputs are zero while and after reset
      repeat (2) @(negedge clk);
      compare_all();
      rst_n = 1'b1;
      // R1 R13 R6: register-register, no address
      cyc(1, 16'h1A34, 16'h2000, 16'h3000, 24'h000100, 2'd3);
      // R2: indexed, index 7 + base 2 + disp, word operand
      cyc(1, 16'h5A37, 16'h2ABC, 16'h0000, 24'h000102, 2'd2);
      // R3: format 2 with a non-zero index field that must be ignored
      cyc(1, 16'h9A37, 16'h2004, 16'h0000, 24'h000104, 2'd2);
      // R4: two-address form, byte operands
      cyc(1, 16'hD212, 16'h3010, 16'h4FFF, 24'h000108, 2'd0);
      // R5: base near 2^24 plus displacement wraps to a low address
      cyc(1, 16'h9000, 16'h5020, 16'h0000, 24'h00010C, 2'd0);
      // R11: idle cycles hold results with out_valid low
      cyc(0, 16'h5FFF, 16'hFFFF, 16'hFFFF, 24'h000001, 2'd3);
      cyc(0, 16'h0000, 16'h0000, 16'h0000, 24'h000000, 2'd0);
      // R7: doubleword at an address ending in 4
      cyc(1, 16'h9000, 16'h3004, 16'h0000, 24'h000110, 2'd3);
      // R7: halfword at odd address, second operand of two-address form
      cyc(1, 16'hD000, 16'h3000, 16'h3001, 24'h000112, 2'd1);
      // R8: odd instruction address, register-register form
      cyc(1, 16'h0512, 16'h0000, 16'h0000, 24'h000115, 2'd0);
      // R9: word ends exactly at the storage limit, legal
      cyc(1, 16'h9000, 16'h6000, 16'h0000, 24'h000116, 2'd2);
      // R9: word starting at the limit, beyond
      cyc(1, 16'h9000, 16'h6004, 16'h0000, 24'h000118, 2'd2);
      // R9: second operand of two-address form beyond the limit
      cyc(1, 16'hD000, 16'h3000, 16'h8010, 24'h00011A, 2'd0);
      // R10: beyond and misaligned together, specification only
      cyc(1, 16'h9000, 16'h6006, 16'h0000, 24'h00011C, 2'd2);
      // R10: odd instruction address with an out-of-range operand
      cyc(1, 16'h5000, 16'h8010, 16'h0000, 24'h00011F, 2'd0);
      // R2: indexed with wrap through the index term
      cyc(1, 16'h4055, 16'h4FFF, 16'h0000, 24'h000120, 2'd0);
      cyc(1, 16'h0000, 16'h0000, 16'h0000, 24'h000122, 2'd0);
      cyc(0, 16'h0000, 16'h0000, 16'h0000, 24'h000000, 2'd0);
      @(negedge clk);
      compare_all();
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

endmodule